// File: doc/BRIEF.md
# Tournament Parent Selector

This block chooses two parent chromosomes for a genetic-algorithm excitation-recovery engine. The chromosomes and their fitness scores sit in a memory outside the block. On each request the block runs two binary tournaments, one after the other. In each tournament it takes two population indices from an internal pseudo-random generator and reads the two fitness scores from the external memory. The index whose score is better goes on as a parent.

Random values that fall beyond the population are thrown away, and a new value is taken on the next cycle. A parameter sets the sense of "better". By default the lower score wins, because the score is an accumulated pattern error. The generator seed can be loaded at any time. The caller uses a start strobe and receives a one-cycle done pulse. Both parent indices then hold their values until the next selection replaces them.

Top module: `tourney_pick`

## Requirements
- R1: After reset, `done` and `fitRdEn` are 0, `parentA` and `parentB` are 0, and the generator holds `RESET_SEED`.
- R2: The generator is a right-shifting Galois register. On each step it shifts right by one, and when the bit shifted out was 1 it XORs `TAP_MASK` (default 16'hB400) into the result. It steps exactly once per draw cycle and never in any other state. Each candidate index is the generator's low `IDX_W` bits as they stand at the start of that draw cycle.
- R3: A candidate that is not below `POP_SIZE` is rejected, and a fresh candidate is taken on the next cycle. Every address driven on `fitAddr` while `fitRdEn` is 1 lies below `POP_SIZE`.
- R4: Once both indices of a tournament are chosen, `fitRdEn` is 1 for exactly two consecutive cycles. The first of those cycles carries the first-drawn index and the second carries the second-drawn index. The memory returns data one cycle after the address, and the comparison uses the second score in the cycle after the second read.
- R5: With `HIGHER_BETTER`=0, the second-drawn index wins only if its fitness is strictly lower. With `HIGHER_BETTER`=1, it wins only if its fitness is strictly higher.
- R6: When the two fitness values are equal, the first-drawn index wins.
- R7: The first tournament writes `parentA` and the second writes `parentB`. `done` is a single-cycle pulse in the cycle after the second comparison. The parent outputs change at no other time.
- R8: When `seedLoad` is 1, `seedValue` replaces the generator state, or 1 if `seedValue` is zero. This takes priority over stepping. A seed loaded in the same cycle as an accepted `start` is the state the first draw uses.
- R9: `start` is accepted in the idle state and in the done cycle. In the done cycle it begins the next selection with no idle cycle between. In every other state it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new parent pair |
| seedLoad | input | 1 | Load the generator seed |
| seedValue | input | LFSR_W | Seed value (zero is mapped to 1) |
| fitAddr | output | IDX_W | Fitness memory read address |
| fitRdEn | output | 1 | Fitness memory read enable |
| fitData | input | FIT_W | Fitness read data, one cycle after the address |
| done | output | 1 | One-cycle pulse when both parents are valid |
| parentA | output | IDX_W | First selected parent index |
| parentB | output | IDX_W | Second selected parent index |

## Verification
Two things can happen in the same cycle, and each needs its own stimulus.

The first case is the done pulse arriving while a new request is made. The bench holds `start` high across whole selections, so the next selection is accepted in the done cycle itself. The reference model must then expect draw cycles to follow directly, with no idle gap.

The second case is a seed load arriving together with an accepted start. Here the model must draw its first candidate from the new seed and not from the old state. For a zero seed it must draw from state 1.

The bench judges both cases cycle by cycle, against the read enable, the read address and the done pulse. It also checks the parents delivered at each done pulse.

// File: rtl/tourney_pkg.sv
package tourney_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAW_A,
    ST_DRAW_B,
    ST_READ_A,
    ST_READ_B,
    ST_COMPARE,
    ST_DONE
  } selState_t;

  typedef struct packed {
    logic drawFirst;
    logic drawSecond;
    logic readFirst;
    logic readSecond;
    logic latchFit;
    logic commitA;
    logic commitB;
  } selStrobe_t;

endpackage

// File: rtl/tourney_ctrl.sv
module tourney_ctrl
  import tourney_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       candOk,
  output selStrobe_t strobe,
  output logic       done
);

  selState_t state, stateNext;
  logic      secondRound, secondRoundNext;

  always_comb begin
    stateNext       = state;
    secondRoundNext = secondRound;
    strobe          = '0;
    done            = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stateNext       = ST_DRAW_A;
          secondRoundNext = 1'b0;
        end
      end
      ST_DRAW_A: begin
        strobe.drawFirst = 1'b1;
        if (candOk) stateNext = ST_DRAW_B;
      end
      ST_DRAW_B: begin
        strobe.drawSecond = 1'b1;
        if (candOk) stateNext = ST_READ_A;
      end
      ST_READ_A: begin
        strobe.readFirst = 1'b1;
        stateNext        = ST_READ_B;
      end
      ST_READ_B: begin
        strobe.readSecond = 1'b1;
        strobe.latchFit   = 1'b1;
        stateNext         = ST_COMPARE;
      end
      ST_COMPARE: begin
        strobe.commitA = ~secondRound;
        strobe.commitB = secondRound;
        if (secondRound) begin
          stateNext = ST_DONE;
        end else begin
          stateNext       = ST_DRAW_A;
          secondRoundNext = 1'b1;
        end
      end
      ST_DONE: begin
        done = 1'b1;
        if (start) begin
          stateNext       = ST_DRAW_A;
          secondRoundNext = 1'b0;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      secondRound <= 1'b0;
    end else begin
      state       <= stateNext;
      secondRound <= secondRoundNext;
    end
  end

endmodule

// File: rtl/tourney_datapath.sv
module tourney_datapath
  import tourney_pkg::*;
#(
  parameter int                 POP_SIZE      = 20,
  parameter int                 FIT_W         = 16,
  parameter int                 LFSR_W        = 16,
  parameter logic [LFSR_W-1:0]  TAP_MASK      = 16'hB400,
  parameter logic [LFSR_W-1:0]  RESET_SEED    = 16'hACE1,
  parameter bit                 HIGHER_BETTER = 1'b0,
  localparam int                IDX_W         = (POP_SIZE > 1) ? $clog2(POP_SIZE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  selStrobe_t        strobe,
  input  logic              seedLoad,
  input  logic [LFSR_W-1:0] seedValue,
  input  logic [FIT_W-1:0]  fitData,
  output logic              candOk,
  output logic [IDX_W-1:0]  fitAddr,
  output logic              fitRdEn,
  output logic [IDX_W-1:0]  parentA,
  output logic [IDX_W-1:0]  parentB
);

  localparam logic [IDX_W:0]  POP_LIMIT = (IDX_W+1)'(POP_SIZE);
  localparam logic [LFSR_W-1:0] ONE_SEED = LFSR_W'(1);

  logic [LFSR_W-1:0] lfsr, lfsrNext;
  logic [IDX_W-1:0]  candidate, idxFirst, idxSecond, winner;
  logic [FIT_W-1:0]  fitFirst;
  logic              secondWins;

  assign lfsrNext  = lfsr[0] ? ((lfsr >> 1) ^ TAP_MASK) : (lfsr >> 1);
  assign candidate = lfsr[IDX_W-1:0];
  assign candOk    = {1'b0, candidate} < POP_LIMIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= RESET_SEED;
    end else if (seedLoad) begin
      lfsr <= (seedValue == '0) ? ONE_SEED : seedValue;
    end else if (strobe.drawFirst || strobe.drawSecond) begin
      lfsr <= lfsrNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idxFirst  <= '0;
      idxSecond <= '0;
      fitFirst  <= '0;
    end else begin
      if (strobe.drawFirst && candOk)  idxFirst  <= candidate;
      if (strobe.drawSecond && candOk) idxSecond <= candidate;
      if (strobe.latchFit)             fitFirst  <= fitData;
    end
  end

  assign fitRdEn = strobe.readFirst | strobe.readSecond;
  assign fitAddr = strobe.readSecond ? idxSecond : idxFirst;

  generate
    if (HIGHER_BETTER) begin : g_higherWins
      assign secondWins = fitData > fitFirst;
    end else begin : g_lowerWins
      assign secondWins = fitData < fitFirst;
    end
  endgenerate

  assign winner = secondWins ? idxSecond : idxFirst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parentA <= '0;
      parentB <= '0;
    end else begin
      if (strobe.commitA) parentA <= winner;
      if (strobe.commitB) parentB <= winner;
    end
  end

endmodule

// File: rtl/tourney_pick.sv
module tourney_pick
  import tourney_pkg::*;
#(
  parameter int                 POP_SIZE      = 20,
  parameter int                 FIT_W         = 16,
  parameter int                 LFSR_W        = 16,
  parameter logic [LFSR_W-1:0]  TAP_MASK      = 16'hB400,
  parameter logic [LFSR_W-1:0]  RESET_SEED    = 16'hACE1,
  parameter bit                 HIGHER_BETTER = 1'b0,
  localparam int                IDX_W         = (POP_SIZE > 1) ? $clog2(POP_SIZE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              seedLoad,
  input  logic [LFSR_W-1:0] seedValue,
  output logic [IDX_W-1:0]  fitAddr,
  output logic              fitRdEn,
  input  logic [FIT_W-1:0]  fitData,
  output logic              done,
  output logic [IDX_W-1:0]  parentA,
  output logic [IDX_W-1:0]  parentB
);

  selStrobe_t strobe;
  logic       candOk;

  tourney_ctrl uCtrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .candOk (candOk),
    .strobe (strobe),
    .done   (done)
  );

  tourney_datapath #(
    .POP_SIZE      (POP_SIZE),
    .FIT_W         (FIT_W),
    .LFSR_W        (LFSR_W),
    .TAP_MASK      (TAP_MASK),
    .RESET_SEED    (RESET_SEED),
    .HIGHER_BETTER (HIGHER_BETTER)
  ) uPath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .seedLoad  (seedLoad),
    .seedValue (seedValue),
    .fitData   (fitData),
    .candOk    (candOk),
    .fitAddr   (fitAddr),
    .fitRdEn   (fitRdEn),
    .parentA   (parentA),
    .parentB   (parentB)
  );

endmodule

// File: rtl/tourney_pick_checker.sv
module tourney_pick_checker #(
  parameter int POP_SIZE = 20,
  parameter int IDX_W    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             fitRdEn,
  input logic [IDX_W-1:0] fitAddr,
  input logic [IDX_W-1:0] parentA,
  input logic [IDX_W-1:0] parentB
);

  assert_read_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fitRdEn |-> (int'(fitAddr) < POP_SIZE));

  assert_parent_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(parentA) < POP_SIZE) && (int'(parentB) < POP_SIZE));

  assert_read_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fitRdEn) |=> fitRdEn);

  assert_read_two_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fitRdEn && $past(fitRdEn)) |=> !fitRdEn);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_parentB_moves_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(parentB) |-> done);

  assert_no_read_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fitRdEn);

endmodule

bind tourney_pick tourney_pick_checker #(.POP_SIZE(POP_SIZE), .IDX_W(IDX_W)) uChk (
  .clk     (clk),
  .rst_n   (rst_n),
  .done    (done),
  .fitRdEn (fitRdEn),
  .fitAddr (fitAddr),
  .parentA (parentA),
  .parentB (parentB)
);

// File: tb/tb_tourney_pick.sv
`timescale 1ns/1ps
module tb_tourney_pick;

  localparam int POP  = 20;
  localparam int FW   = 16;
  localparam int LW   = 16;
  localparam int IW   = 5;
  localparam int MASK = 'hB400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          seedLoad = 1'b0;
  logic [LW-1:0] seedValue = '0;
  logic [IW-1:0] fitAddr;
  logic          fitRdEn;
  logic [FW-1:0] fitData = '0;
  logic          done;
  logic [IW-1:0] parentA, parentB;

  logic [FW-1:0] fitMem [POP];

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string curTag = "R5";

  // Reference model state
  int mLfsr;
  int q[$];
  int expA, expB, heldA, heldB;

  always #4 clk = ~clk;   // 125 MHz

  tourney_pick dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seedLoad(seedLoad),
    .seedValue(seedValue), .fitAddr(fitAddr), .fitRdEn(fitRdEn),
    .fitData(fitData), .done(done), .parentA(parentA), .parentB(parentB)
  );

  // Synchronous fitness memory, one-cycle latency
  always @(posedge clk) if (fitRdEn) fitData <= fitMem[fitAddr];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int stepLfsr(input int s);
    return (s & 1) ? ((s >> 1) ^ MASK) : (s >> 1);
  endfunction

  // Entry encoding: bit9 done, bit8 read, bits7:0 address
  function automatic int drawIdx();
    int v;
    do begin
      v = mLfsr & ((1 << IW) - 1);
      mLfsr = stepLfsr(mLfsr);
      q.push_back(0);
    end while (v >= POP);
    return v;
  endfunction

  task automatic buildRun();
    for (int p = 0; p < 2; p++) begin
      int a, b, w;
      a = drawIdx();
      b = drawIdx();
      q.push_back(256 | a);
      q.push_back(256 | b);
      q.push_back(0);
      w = (fitMem[b] < fitMem[a]) ? b : a;
      if (p == 0) expA = w; else expB = w;
    end
    q.push_back(512);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mLfsr = 'hACE1;
      q.delete();
    end else begin
      if (seedLoad) mLfsr = (seedValue == 0) ? 1 : int'(seedValue);
      if (start && q.size() == 0) buildRun();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0) begin
        int e;
        e = q.pop_front();
        check(done == e[9], "R7 done", done, e[9]);
        check(fitRdEn == e[8], "R4 read enable", fitRdEn, e[8]);
        if (e[8]) check(fitAddr == e[7:0], "R2/R3 read address", fitAddr, e[7:0]);
        if (e[9]) begin
          check(parentA == expA, {curTag, " parentA"}, parentA, expA);
          check(parentB == expB, {curTag, " parentB"}, parentB, expB);
          heldA = expA;
          heldB = expB;
        end
      end else begin
        check(!done && !fitRdEn, "R9 idle quiet", {done, fitRdEn}, 0);
        check(parentA == heldA && parentB == heldB, "R7 parents hold",
              {parentA, parentB}, {heldA[IW-1:0], heldB[IW-1:0]});
      end
    end
  end

  always @(posedge clk) begin
    if (cycles == 150000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic waitIdle();
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    #1;
  endtask

  task automatic runOnce();
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    waitIdle();
  endtask

  initial begin
    heldA = 0; heldB = 0; expA = 0; expB = 0;
    for (int i = 0; i < POP; i++) fitMem[i] = FW'(1000 + i * 37 % 101);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done == 0, "R1 done", done, 0);
    check(fitRdEn == 0, "R1 read enable", fitRdEn, 0);
    check(parentA == 0 && parentB == 0, "R1 parents", {parentA, parentB}, 0);

    // R5 lower fitness wins, varied patterns
    curTag = "R5";
    for (int k = 0; k < 6; k++) runOnce();
    for (int i = 0; i < POP; i++) fitMem[i] = FW'(i * 50);        // ascending
    for (int k = 0; k < 4; k++) runOnce();
    for (int i = 0; i < POP; i++) fitMem[i] = FW'(5000 - i * 50); // descending
    for (int k = 0; k < 4; k++) runOnce();

    // R6 ties: first-drawn index wins
    curTag = "R6";
    for (int i = 0; i < POP; i++) fitMem[i] = 16'd777;
    for (int k = 0; k < 4; k++) runOnce();
    for (int i = 0; i < POP; i++) fitMem[i] = FW'((i % 3) * 10);
    for (int k = 0; k < 4; k++) runOnce();

    // R8 seed load in idle, zero seed mapped to 1
    curTag = "R8";
    @(negedge clk); #1 seedLoad = 1'b1; seedValue = '0;
    @(negedge clk); #1 seedLoad = 1'b0;
    runOnce();
    // R8 seed load in the same cycle as start
    @(negedge clk); #1 seedLoad = 1'b1; seedValue = 16'h1234; start = 1'b1;
    @(negedge clk); #1 seedLoad = 1'b0; start = 1'b0;
    waitIdle();
    @(negedge clk); #1 seedLoad = 1'b1; seedValue = 16'h0000; start = 1'b1;
    @(negedge clk); #1 seedLoad = 1'b0; start = 1'b0;
    waitIdle();

    // R9 start held high: ignored mid-run, accepted in done cycle
    curTag = "R9";
    for (int i = 0; i < POP; i++) fitMem[i] = FW'((i * 7919) % 4093);
    @(negedge clk); #1 start = 1'b1;
    repeat (120) @(negedge clk);
    #1 start = 1'b0;
    waitIdle();
    repeat (5) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule